// File: doc/BRIEF.md
# Halving Partial-Sum Reduction Engine

This block folds a set of signed per-lane partial sums into one grand total. A start pulse loads all lanes at once from a flat input bus. The engine then runs a sequence of reduction rounds, one per clock. In each round a live count of active lanes is halved, and every lane below the new count adds in the lane that sits that many positions above it. When the live count is odd, lane 0 first takes in the element that would otherwise be left over. Because of this, the lane count does not need to be a power of two.

All additions in a round read the values that stood at the start of that round, and all results are written on a single clock edge. This register boundary acts as the barrier between rounds. When the count reaches one, lane 0 holds the exact total and a one-cycle done pulse is raised. The sum width grows by ceil(log2 N) bits over the input width, so the total cannot overflow.

Top module: `halving_reducer`

## Requirements
- R1: When idle, a start pulse sampled high loads every lane i from `data_i[i*IN_W +: IN_W]` as a two's-complement value, sign-extended to SUM_W = IN_W + ceil(log2 LANES) bits, and sets the live count to LANES.
- R2: In a round where the live count is odd, lane 0 also adds the element at index count-1, before the count is halved.
- R3: Each round runs in one clock. The count becomes floor(count/2), and every lane i below the new count adds the element at index i plus the new count. All operands are taken from the values held before that edge.
- R4: If the start is sampled at edge 0, `done_o` is high in the cycle after edge K and not before. K is the number of halvings needed to take LANES down to 1 (3 for 10 lanes, 2 for 7 lanes).
- R5: While `done_o` is high, `total_o` equals the exact signed sum of the loaded lanes, including all-minimum and all-maximum inputs.
- R6: `done_o` is high for exactly one cycle. `total_o` keeps the result until the next start is accepted.
- R7: A start pulse while a reduction is running is ignored: the result and the done timing are those of the reduction already in progress.
- R8: With LANES = 1, `done_o` rises right after the start edge and `total_o` carries the loaded value, with no rounds in between.
- R9: After reset, `done_o` is low and `total_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| data_i | input | LANES*IN_W | Packed signed partial sums, lane 0 in the low bits |
| done_o | output | 1 | One-cycle flag marking a valid total |
| total_o | output | SUM_W | Signed grand total (lane 0) |

## Verification
Two functions can meet in one cycle: the odd-count fold into lane 0 and lane 0's ordinary pairwise add. Both land on lane 0 on the same edge, and the fold source is never the pair partner. This is provoked with 10 lanes (count 5 folds lane 4 while lane 0 adds lane 2) and with 7 lanes (two consecutive folding rounds). Distinct per-lane values make any dropped or doubled term visible in the final total. A second collision, a start arriving while a reduction runs, is driven mid-run, and it is judged by checking that the total and the done cycle are unchanged.

// File: rtl/hr_pkg.sv
package hr_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } hr_state_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 1) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/hr_ctrl.sv
module hr_ctrl #(
  parameter int LANES  = 10,
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              load_en_o,
  output logic              step_en_o,
  output logic              run_o,
  output logic              done_o,
  output logic              fold_o,
  output logic [HALF_W-1:0] half_q_o,
  output logic [HALF_W-1:0] half_nxt_o
);
  import hr_pkg::*;

  hr_state_e         state_q, state_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic              half_en;
  logic              done_q, done_d;

  assign load_en_o  = (state_q == ST_IDLE) && start_i;
  assign step_en_o  = (state_q == ST_RUN);
  assign half_nxt_o = half_q >> 1;
  assign fold_o     = half_q[0];
  assign half_en    = load_en_o || step_en_o;

  always_comb begin
    state_d = state_q;
    half_d  = half_q;
    done_d  = 1'b0;
    if (load_en_o) begin
      half_d = HALF_W'(LANES);
      if (LANES == 1) done_d  = 1'b1;
      else            state_d = ST_RUN;
    end else if (step_en_o) begin
      half_d = half_nxt_o;
      if (half_nxt_o == HALF_W'(1)) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      half_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (half_en) half_q <= half_d;
    end
  end

  assign run_o    = (state_q == ST_RUN);
  assign done_o   = done_q;
  assign half_q_o = half_q;

endmodule

// File: rtl/hr_lane_array.sv
module hr_lane_array #(
  parameter int LANES  = 10,
  parameter int IN_W   = 16,
  parameter int SUM_W  = 20,
  parameter int HALF_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en_i,
  input  logic                  step_en_i,
  input  logic                  fold_i,
  input  logic [HALF_W-1:0]     half_q_i,
  input  logic [HALF_W-1:0]     half_nxt_i,
  input  logic [LANES*IN_W-1:0] data_i,
  output logic [SUM_W-1:0]      elem0_o
);
  localparam int IDX_W = HALF_W + 1;

  logic [SUM_W-1:0] elem_q [LANES];
  logic [SUM_W-1:0] elem_d [LANES];
  logic             elem_en;

  // Select a lane value by a run-time index; out-of-range gives zero.
  function automatic logic [SUM_W-1:0] pick(input logic [IDX_W-1:0] idx);
    logic [SUM_W-1:0] v;
    v = '0;
    for (int j = 0; j < LANES; j++)
      if (idx == IDX_W'(j)) v = elem_q[j];
    return v;
  endfunction

  assign elem_en = load_en_i || step_en_i;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      elem_d[i] = elem_q[i];
      if (load_en_i) begin
        elem_d[i] = SUM_W'(signed'(data_i[i*IN_W +: IN_W]));
      end else if (step_en_i) begin
        if (IDX_W'(i) < {1'b0, half_nxt_i})
          elem_d[i] = elem_q[i] + pick(IDX_W'(i) + {1'b0, half_nxt_i});
        if (i == 0 && fold_i)
          elem_d[i] = elem_d[i] + pick({1'b0, half_q_i} - IDX_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) elem_q[i] <= '0;
    end else if (elem_en) begin
      for (int i = 0; i < LANES; i++) elem_q[i] <= elem_d[i];
    end
  end

  assign elem0_o = elem_q[0];

endmodule

// File: rtl/halving_reducer.sv
module halving_reducer #(
  parameter int LANES = 10,
  parameter int IN_W  = 16,
  localparam int SUM_W  = IN_W + $clog2(LANES),
  localparam int HALF_W = hr_pkg::clog2_min1(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [LANES*IN_W-1:0] data_i,
  output logic                  done_o,
  output logic [SUM_W-1:0]      total_o
);
  logic              load_en_w, step_en_w, run_w, fold_w;
  logic [HALF_W-1:0] half_w, half_nxt_w;

  hr_ctrl #(.LANES(LANES), .HALF_W(HALF_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .load_en_o  (load_en_w),
    .step_en_o  (step_en_w),
    .run_o      (run_w),
    .done_o     (done_o),
    .fold_o     (fold_w),
    .half_q_o   (half_w),
    .half_nxt_o (half_nxt_w)
  );

  hr_lane_array #(.LANES(LANES), .IN_W(IN_W), .SUM_W(SUM_W), .HALF_W(HALF_W)) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en_i  (load_en_w),
    .step_en_i  (step_en_w),
    .fold_i     (fold_w),
    .half_q_i   (half_w),
    .half_nxt_i (half_nxt_w),
    .data_i     (data_i),
    .elem0_o    (total_o)
  );

endmodule

// File: rtl/hr_chk.sv
module hr_chk #(
  parameter int LANES  = 10,
  parameter int SUM_W  = 20,
  parameter int HALF_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              done_o,
  input logic [SUM_W-1:0]  total_o,
  input logic              run_q,
  input logic [HALF_W-1:0] half_q
);

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: result held after done while no new start arrives
  a_r6_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable(total_o));

  // R3: each running cycle halves the live count
  a_r3_count_halves: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (half_q == ($past(half_q) >> 1)));

  // R7: a start during a run does not reload the count
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start_i) |=> (half_q != HALF_W'(LANES)));

  // R1: a run only begins after a sampled start
  a_r1_run_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(start_i));

  // R4: done never overlaps a running round
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !run_q);

endmodule

bind halving_reducer hr_chk #(.LANES(LANES), .SUM_W(SUM_W), .HALF_W(HALF_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .done_o  (done_o),
  .total_o (total_o),
  .run_q   (run_w),
  .half_q  (half_w)
);

// File: tb/sim_halving_reducer.sv
module sim_halving_reducer;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic start0, start1, start2;
  logic [79:0] data0;
  logic [7:0]  data1;
  logic [55:0] data2;
  logic done0, done1, done2;
  logic [11:0] tot0;
  logic [7:0]  tot1;
  logic [10:0] tot2;

  int n_chk, n_fail;

  halving_reducer #(.LANES(10), .IN_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start0), .data_i(data0), .done_o(done0), .total_o(tot0));
  halving_reducer #(.LANES(1), .IN_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start1), .data_i(data1), .done_o(done1), .total_o(tot1));
  halving_reducer #(.LANES(7), .IN_W(8)) u2 (
    .clk(clk), .rst_n(rst_n), .start_i(start2), .data_i(data2), .done_o(done2), .total_o(tot2));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lanes_of(input int sel);
    return (sel == 0) ? 10 : (sel == 1) ? 1 : 7;
  endfunction

  function automatic logic get_done(input int sel);
    return (sel == 0) ? done0 : (sel == 1) ? done1 : done2;
  endfunction

  function automatic int get_tot(input int sel);
    return (sel == 0) ? int'($signed(tot0)) : (sel == 1) ? int'($signed(tot1)) : int'($signed(tot2));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_start(input int sel, input logic v);
    case (sel)
      0: start0 = v;
      1: start1 = v;
      default: start2 = v;
    endcase
  endtask

  task automatic set_data(input int sel, input int vals[10]);
    for (int k = 0; k < 10; k++) begin
      if (sel == 0) data0[k*8 +: 8] = vals[k][7:0];
      if (sel == 1 && k < 1) data1[k*8 +: 8] = vals[k][7:0];
      if (sel == 2 && k < 7) data2[k*8 +: 8] = vals[k][7:0];
    end
  endtask

  // One reduction; poke drives a second start mid-run (R7).
  task automatic run_case(input int sel, input int vals[10], input string tag, input bit poke);
    int n, h, rounds, exp, cyc, held;
    int junk[10];
    bit seen;
    n = lanes_of(sel);
    exp = 0;
    for (int k = 0; k < n; k++) exp += vals[k];
    h = n; rounds = 0;
    while (h > 1) begin h = h / 2; rounds++; end
    for (int k = 0; k < 10; k++) junk[k] = 100 - 7 * k;
    @(negedge clk);
    set_data(sel, vals);
    set_start(sel, 1'b1);
    cyc = 0; seen = 0;
    while (!seen && cyc < 40) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (cyc == 1 && !poke) set_start(sel, 1'b0);
      if (cyc == 1 && poke) set_data(sel, junk);
      if (cyc == 2 && poke) set_start(sel, 1'b0);
      if (get_done(sel)) seen = 1;
    end
    set_start(sel, 1'b0);
    check({tag, " R4 done cycle"}, cyc, rounds + 1);
    check({tag, " R5 total"}, get_tot(sel), exp);
    held = get_tot(sel);
    @(negedge clk);
    check({tag, " R6 done pulse"}, int'(get_done(sel)), 0);
    check({tag, " R6 total held"}, get_tot(sel), held);
  endtask

  task automatic t_reset;
    check("R9 reset done u0", int'(done0), 0);
    check("R9 reset done u2", int'(done2), 0);
    check("R9 reset total u0", int'($signed(tot0)), 0);
  endtask

  task automatic t_ascending;
    run_case(0, '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10}, "R1/R3 ascending", 1'b0);
  endtask

  task automatic t_mixed;
    run_case(0, '{-3, 17, -100, 42, 5, -9, 64, -1, 27, -50}, "R1/R2 mixed signs", 1'b0);
  endtask

  task automatic t_extremes;
    run_case(0, '{-128, -128, -128, -128, -128, -128, -128, -128, -128, -128}, "R5 all min", 1'b0);
    run_case(0, '{127, 127, 127, 127, 127, 127, 127, 127, 127, 127}, "R5 all max", 1'b0);
  endtask

  task automatic t_busy_start;
    run_case(0, '{11, -22, 33, -44, 55, -66, 77, -88, 99, 1}, "R7 start while busy", 1'b1);
  endtask

  task automatic t_odd_lanes;
    run_case(2, '{1, 20, 300 - 256, -4, 50, -60, 7, 0, 0, 0}, "R2 seven lanes", 1'b0);
    run_case(2, '{-128, 127, -128, 127, -128, 127, -128, 0, 0, 0}, "R2/R5 seven lanes extremes", 1'b0);
  endtask

  task automatic t_single;
    run_case(1, '{-5, 0, 0, 0, 0, 0, 0, 0, 0, 0}, "R8 single lane", 1'b0);
    run_case(1, '{127, 0, 0, 0, 0, 0, 0, 0, 0, 0}, "R8 single lane max", 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    start0 = 1'b0; start1 = 1'b0; start2 = 1'b0;
    data0 = '0; data1 = '0; data2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ascending();
    t_mixed();
    t_extremes();
    t_busy_start();
    t_odd_lanes();
    t_single();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule